// File: doc/BRIEF.md
# Stereo Playback Sample Queue with Rate Timer

This block sits between a processor-side write port and a sigma-delta modulator. Software writes stereo PCM, one 20-bit left word and one 20-bit right word at a time, into a queue that holds up to four such pairs. A rate timer produces two pulses. The first is an oversampling enable at 256 times the chosen sample rate. The second is a sample strobe once per sample period. On each sample strobe the oldest pair leaves the queue and is held on the output registers, where the modulator reads it.

Two master clocks exist, one of the 24.576 MHz family and one of the 22.5792 MHz family. Both reach the block as clock-enable inputs in the system clock domain. A 4-bit rate code picks the master clock family and also the divide ratio from that clock to the oversampling rate. Writing an accepted code restarts the timer. The timer is a two-state machine. Reset enters `RT_RESTART`, which clears both counters for one cycle. The transition `RT_RESTART -> RT_RUN` is taken unconditionally. The transition `RT_RUN -> RT_RESTART` is taken on any accepted rate write, and an accepted write while in `RT_RESTART` keeps the machine in `RT_RESTART`. Sticky flags report reading from an empty queue and writing to a full one. A clear pulse resets both flags.

Top module: `pcm_playout`

## Requirements
- R1: After reset the level is 0, empty is 1, full is 0, both sticky flags are 0, the output pair is zero, both timing pulses are low, and rate code 0 (48 kHz) is selected.
- R2: Rate codes: 0 = 48 kHz, 24.576 MHz family, divide 2; 1 = 44.1 kHz, 22.5792 MHz family, divide 2; 2 = 32 kHz, 24.576 MHz family, divide 3; 3 = 24 kHz, 24.576 MHz family, divide 4; 4 = 22.05 kHz, 22.5792 MHz family, divide 4; 5 = 16 kHz, 24.576 MHz family, divide 6; 6 = 12 kHz, 24.576 MHz family, divide 8; 7 = 11.025 kHz, 22.5792 MHz family, divide 8; 8 = 8 kHz, 24.576 MHz family, divide 12. Consecutive sample strobes are 256 × divide enables of the selected family apart.
- R3: `os_en` is a one-cycle pulse on every divide-th enable of the selected family. `smp_stb` is high only together with `os_en`, on every 256th `os_en`.
- R4: A rate write carrying a code from 9 to 15 is ignored. The rate stays the same and the timer is not restarted.
- R5: An accepted rate write clears the timer. No pulse appears in the cycle after the write. With the family enable held high, the first strobe comes 256 × divide + 2 cycles after the write cycle.
- R6: The queue holds at most four pairs. `fifo_level` counts them. `fifo_full` is high when the level is 4 and `fifo_empty` is high when the level is 0.
- R7: A strobe removes the oldest pair. That pair appears on `out_left`/`out_right` from the next cycle on, and pairs leave in the order they were written.
- R8: A strobe while the queue is empty leaves the output pair unchanged and sets the sticky `underrun` flag.
- R9: A write while the queue is full and no strobe is present is dropped and sets the sticky `overflow` flag.
- R10: A write in a strobe cycle while the queue is full is accepted. The level stays at 4 and `overflow` is not set.
- R11: `flag_clr` clears both sticky flags. If a new underrun or overflow event occurs in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk48_en | input | 1 | Enable marking each 24.576 MHz family master tick |
| mclk44_en | input | 1 | Enable marking each 22.5792 MHz family master tick |
| cfg_we | input | 1 | Rate register write strobe |
| cfg_rate | input | 4 | Rate code written with `cfg_we` |
| flag_clr | input | 1 | Clears the sticky flags |
| wr_en | input | 1 | Pair write strobe |
| wr_left | input | 20 | Left PCM word to write |
| wr_right | input | 20 | Right PCM word to write |
| os_en | output | 1 | Oversampling enable at 256 × FS |
| smp_stb | output | 1 | Once-per-sample strobe |
| out_left | output | 20 | Left word released to the modulator |
| out_right | output | 20 | Right word released to the modulator |
| fifo_level | output | 3 | Number of stored pairs |
| fifo_full | output | 1 | Queue holds four pairs |
| fifo_empty | output | 1 | Queue holds no pairs |
| underrun | output | 1 | Sticky: a strobe found the queue empty |
| overflow | output | 1 | Sticky: a write found the queue full |

## Verification
A processor write and a sample-strobe pop can occur in the same cycle. This case is hardest when the queue is full, since the write must be kept, or empty, since the pop must record an underrun while the write still lands. The bench computes the next strobe cycle from the known period and times a write to fall exactly on it. A reference queue in the bench, updated from the cycle's inputs, then judges the level, flags and output pair. A clear pulse is placed on a strobe cycle in the same way, to show that a new underrun outlives the clear.

// File: rtl/pcm_playout_pkg.sv
`timescale 1ns/1ps
package pcm_playout_pkg;

    localparam int unsigned RATE_CODE_W = 4;
    localparam int unsigned DIV_W       = 4;

    typedef struct packed {
        logic             valid;
        logic             fam44;
        logic [DIV_W-1:0] div;
    } rate_cfg_t;

    // Map a rate code to its master clock family and its divide ratio to 256xFS.
    function automatic rate_cfg_t rate_decode(input logic [RATE_CODE_W-1:0] code);
        rate_cfg_t r;
        r.valid = 1'b1;
        r.fam44 = 1'b0;
        r.div   = DIV_W'(2);
        case (code)
            4'd0: r.div = DIV_W'(2);
            4'd1: begin r.fam44 = 1'b1; r.div = DIV_W'(2); end
            4'd2: r.div = DIV_W'(3);
            4'd3: r.div = DIV_W'(4);
            4'd4: begin r.fam44 = 1'b1; r.div = DIV_W'(4); end
            4'd5: r.div = DIV_W'(6);
            4'd6: r.div = DIV_W'(8);
            4'd7: begin r.fam44 = 1'b1; r.div = DIV_W'(8); end
            4'd8: r.div = DIV_W'(12);
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcm_playout_timer.sv
`timescale 1ns/1ps
module pcm_playout_timer
    import pcm_playout_pkg::*;
#(
    parameter int unsigned OS_RATIO = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fam48_en,
    input  logic                   fam44_en,
    input  logic                   cfg_we,
    input  logic [RATE_CODE_W-1:0] cfg_rate,
    output logic                   os_en,
    output logic                   smp_stb
);

    localparam int unsigned OS_W = $clog2(OS_RATIO);

    typedef enum logic {
        RT_RESTART,
        RT_RUN
    } rt_state_e;

    rt_state_e              state_q, state_d;
    logic [RATE_CODE_W-1:0] rate_q;
    logic [DIV_W-1:0]       div_cnt;
    logic [OS_W-1:0]        os_cnt;
    rate_cfg_t              cur_cfg, req_cfg;
    logic                   rate_load, fam_tick, div_last, os_last;

    assign cur_cfg   = rate_decode(rate_q);
    assign req_cfg   = rate_decode(cfg_rate);
    assign rate_load = cfg_we && req_cfg.valid;
    assign fam_tick  = cur_cfg.fam44 ? fam44_en : fam48_en;
    assign div_last  = (div_cnt == DIV_W'(cur_cfg.div - DIV_W'(1)));
    assign os_last   = (os_cnt == OS_W'(OS_RATIO - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RT_RESTART;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_RESTART: state_d = RT_RUN;
            RT_RUN:     state_d = RT_RUN;
        endcase
        if (rate_load) state_d = RT_RESTART;
    end

    // Counters and timing outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q  <= '0;
            div_cnt <= '0;
            os_cnt  <= '0;
            os_en   <= 1'b0;
            smp_stb <= 1'b0;
        end else begin
            os_en   <= 1'b0;
            smp_stb <= 1'b0;
            if (rate_load) begin
                rate_q  <= cfg_rate;
                div_cnt <= '0;
                os_cnt  <= '0;
            end else begin
                unique case (state_q)
                    RT_RESTART: begin
                        div_cnt <= '0;
                        os_cnt  <= '0;
                    end
                    RT_RUN: begin
                        if (fam_tick) begin
                            if (div_last) begin
                                div_cnt <= '0;
                                os_en   <= 1'b1;
                                os_cnt  <= os_last ? '0 : os_cnt + OS_W'(1);
                                if (os_last) smp_stb <= 1'b1;
                            end else begin
                                div_cnt <= div_cnt + DIV_W'(1);
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R3
    strobe_with_os_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> os_en);

    // R3
    os_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        os_en |=> !os_en);

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rate_load |=> (!os_en && !smp_stb && state_q == RT_RESTART));

    // R4
    bad_code_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !req_cfg.valid) |=> $stable(rate_q));

endmodule

// File: rtl/pcm_playout_fifo.sv
`timescale 1ns/1ps
module pcm_playout_fifo #(
    parameter int unsigned DATA_W = 20,
    parameter int unsigned DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_l,
    input  logic [DATA_W-1:0] push_r,
    input  logic              pop_req,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic              full,
    output logic              empty,
    output logic              underrun,
    output logic              overflow
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] slot_l [DEPTH];
    logic [DATA_W-1:0] slot_r [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              push_ok, pop_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign pop_ok  = pop_req && !empty;
    assign push_ok = push_req && (!full || pop_req);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PTR_W'(g)) begin
                slot_l[g] <= push_l;
                slot_r[g] <= push_r;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            out_l    <= '0;
            out_r    <= '0;
            underrun <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
                out_l  <= slot_l[rd_ptr];
                out_r  <= slot_r[rd_ptr];
            end
            unique case ({push_ok, pop_ok})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
            underrun <= (underrun && !flag_clr) || (pop_req && empty);
            overflow <= (overflow && !flag_clr) || (push_req && full && !pop_req);
        end
    end

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    // R6
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R8
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> (underrun && $stable(out_l) && $stable(out_r)));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> (overflow && $stable(level)));

    // R10
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && full) |=> (full && $stable(level)));

    // R11
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(pop_req && empty)) |=> !underrun);

endmodule

// File: rtl/pcm_playout.sv
`timescale 1ns/1ps
module pcm_playout
    import pcm_playout_pkg::*;
#(
    parameter int unsigned DATA_W   = 20,
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned OS_RATIO = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mclk48_en,
    input  logic                        mclk44_en,
    input  logic                        cfg_we,
    input  logic [RATE_CODE_W-1:0]      cfg_rate,
    input  logic                        flag_clr,
    input  logic                        wr_en,
    input  logic [DATA_W-1:0]           wr_left,
    input  logic [DATA_W-1:0]           wr_right,
    output logic                        os_en,
    output logic                        smp_stb,
    output logic [DATA_W-1:0]           out_left,
    output logic [DATA_W-1:0]           out_right,
    output logic [$clog2(DEPTH+1)-1:0]  fifo_level,
    output logic                        fifo_full,
    output logic                        fifo_empty,
    output logic                        underrun,
    output logic                        overflow
);

    pcm_playout_timer #(
        .OS_RATIO (OS_RATIO)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fam48_en (mclk48_en),
        .fam44_en (mclk44_en),
        .cfg_we   (cfg_we),
        .cfg_rate (cfg_rate),
        .os_en    (os_en),
        .smp_stb  (smp_stb)
    );

    pcm_playout_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_en),
        .push_l   (wr_left),
        .push_r   (wr_right),
        .pop_req  (smp_stb),
        .flag_clr (flag_clr),
        .out_l    (out_left),
        .out_r    (out_right),
        .level    (fifo_level),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .underrun (underrun),
        .overflow (overflow)
    );

endmodule

// File: tb/pcm_playout_tb_top.sv
`timescale 1ns/1ps
module pcm_playout_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mclk48_en, mclk44_en, cfg_we, flag_clr, wr_en;
    logic [3:0]  cfg_rate;
    logic [19:0] wr_left, wr_right;
    logic        os_en, smp_stb, fifo_full, fifo_empty, underrun, overflow;
    logic [19:0] out_left, out_right;
    logic [2:0]  fifo_level;

    always #2.5 clk = ~clk;

    pcm_playout dut_i (
        .clk(clk), .rst_n(rst_n), .mclk48_en(mclk48_en), .mclk44_en(mclk44_en),
        .cfg_we(cfg_we), .cfg_rate(cfg_rate), .flag_clr(flag_clr), .wr_en(wr_en),
        .wr_left(wr_left), .wr_right(wr_right), .os_en(os_en), .smp_stb(smp_stb),
        .out_left(out_left), .out_right(out_right), .fifo_level(fifo_level),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .underrun(underrun),
        .overflow(overflow)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stb_count = 0;
    int last_stb_cyc = 0;
    int os_since = 0;
    int cur_period = 512;

    // scoreboard state
    logic [19:0] q_l[$];
    logic [19:0] q_r[$];
    logic [19:0] exp_l, exp_r;
    logic        exp_under, exp_over;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // R2: 22.5792 MHz family enable ticks every second cycle
    initial begin
        mclk44_en = 1'b0;
        forever begin
            @(posedge clk); #1;
            mclk44_en = ~mclk44_en;
        end
    end

    // Monitor and scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            q_l.delete(); q_r.delete();
            exp_l = '0; exp_r = '0; exp_under = 1'b0; exp_over = 1'b0;
            os_since = 0;
        end else begin
            bit was_empty, was_full;
            chk(fifo_level == q_l.size(), "R6", "level", fifo_level, q_l.size());
            chk(fifo_full == (q_l.size() == 4), "R6", "full", fifo_full, q_l.size() == 4);
            chk(fifo_empty == (q_l.size() == 0), "R6", "empty", fifo_empty, q_l.size() == 0);
            chk(out_left == exp_l, "R7", "out_left", out_left, exp_l);
            chk(out_right == exp_r, "R7", "out_right", out_right, exp_r);
            chk(underrun == exp_under, "R8", "underrun", underrun, exp_under);
            chk(overflow == exp_over, "R9", "overflow", overflow, exp_over);
            if (os_en) os_since++;
            if (smp_stb) begin
                chk(os_since == 256, "R3", "os_en per strobe", os_since, 256);
                os_since = 0;
                last_stb_cyc = cyc;
                stb_count++;
            end
            if (cfg_we && cfg_rate <= 4'd8) os_since = 0;
            was_empty = (q_l.size() == 0);
            was_full  = (q_l.size() == 4);
            if (smp_stb && !was_empty) begin
                exp_l = q_l.pop_front();
                exp_r = q_r.pop_front();
            end
            if (wr_en && (!was_full || smp_stb)) begin
                q_l.push_back(wr_left);
                q_r.push_back(wr_right);
            end
            exp_under = (exp_under && !flag_clr) || (smp_stb && was_empty);
            exp_over  = (exp_over && !flag_clr) || (wr_en && was_full && !smp_stb);
        end
    end

    task automatic wait_stb();
        int n = stb_count;
        wait (stb_count > n);
    endtask

    task automatic write_pair(input logic [19:0] l, input logic [19:0] r);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_left = l; wr_right = r;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_rate(input logic [3:0] code, output int wcyc);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_rate = code; wcyc = cyc;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clear();
        @(posedge clk); #1; flag_clr = 1'b1;
        @(posedge clk); #1; flag_clr = 1'b0;
    endtask

    task automatic run_to(input int target);
        while (cyc < target) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        finish_run();
    end

    int div_tab[9] = '{2, 2, 3, 4, 4, 6, 8, 8, 12};
    bit f44_tab[9] = '{0, 1, 0, 0, 1, 0, 0, 1, 0};

    initial begin
        int s, w, prev;
        rst_n = 1'b0; mclk48_en = 1'b1; cfg_we = 1'b0; cfg_rate = '0;
        flag_clr = 1'b0; wr_en = 1'b0; wr_left = '0; wr_right = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fifo_level == 0, "R1", "level", fifo_level, 0);
        chk(fifo_empty == 1 && fifo_full == 0, "R1", "empty/full", {fifo_empty, fifo_full}, 2);
        chk(out_left == 0 && out_right == 0, "R1", "out pair", out_left, 0);
        chk(!underrun && !overflow, "R1", "flags", {underrun, overflow}, 0);
        chk(!os_en && !smp_stb, "R1", "pulses", {os_en, smp_stb}, 0);

        // R1 default rate 48 kHz: period 512
        wait_stb(); s = last_stb_cyc;
        wait_stb();
        chk(last_stb_cyc - s == 512, "R1", "default period", last_stb_cyc - s, 512);

        // R6 R9 fill beyond capacity right after a strobe
        wait_stb();
        for (int i = 0; i < 5; i++) write_pair(20'h10000 + i, 20'h20000 + i);
        @(negedge clk);
        chk(fifo_full == 1, "R6", "full after fill", fifo_full, 1);
        chk(overflow == 1, "R9", "overflow after fifth write", overflow, 1);

        // R7 R8 drain past empty
        repeat (5) wait_stb();
        @(negedge clk);
        chk(underrun == 1, "R8", "underrun after drain", underrun, 1);
        chk(out_left == 20'h10003 && out_right == 20'h20003, "R8", "held pair", out_left, 20'h10003);

        // R11 plain clear
        pulse_clear();
        @(negedge clk);
        chk(!underrun && !overflow, "R11", "cleared", {underrun, overflow}, 0);

        // R11 clear in the same cycle as an empty pop
        wait_stb(); s = last_stb_cyc;
        run_to(s + 512);
        flag_clr = 1'b1;
        @(posedge clk); #1; flag_clr = 1'b0;
        @(negedge clk);
        chk(underrun == 1, "R11", "event beats clear", underrun, 1);
        pulse_clear();

        // R10 write in the strobe cycle with a full queue
        wait_stb(); s = last_stb_cyc;
        for (int i = 0; i < 4; i++) write_pair(20'h30000 + i, 20'h40000 + i);
        run_to(s + 512);
        wr_en = 1'b1; wr_left = 20'h3AAAA; wr_right = 20'h4AAAA;
        @(posedge clk); #1; wr_en = 1'b0;
        @(negedge clk);
        chk(fifo_level == 4, "R10", "level stays full", fifo_level, 4);
        chk(overflow == 0, "R10", "no overflow", overflow, 0);
        chk(out_left == 20'h30000, "R10", "oldest pair out", out_left, 20'h30000);

        // R8 with a write landing in an empty pop cycle: drain first
        repeat (4) wait_stb();
        pulse_clear();
        wait_stb(); s = last_stb_cyc;
        run_to(s + 512);
        wr_en = 1'b1; wr_left = 20'h55555; wr_right = 20'h66666;
        @(posedge clk); #1; wr_en = 1'b0;
        @(negedge clk);
        chk(underrun == 1 && fifo_level == 1, "R8", "empty pop with write", {underrun, fifo_level}, 9);
        wait_stb();
        @(negedge clk);
        chk(out_left == 20'h55555, "R7", "late pair out", out_left, 20'h55555);
        pulse_clear();

        // R4 invalid codes ignored
        wait_stb(); s = last_stb_cyc;
        set_rate(4'd12, w);
        set_rate(4'd15, w);
        wait_stb();
        chk(last_stb_cyc - s == 512, "R4", "period kept", last_stb_cyc - s, 512);

        // R5 restart mid-period with the same code
        wait_stb();
        repeat (200) @(posedge clk);
        set_rate(4'd0, w);
        wait_stb();
        chk(last_stb_cyc - w == 514, "R5", "first strobe delay", last_stb_cyc - w, 514);

        // R2 R5 sweep all codes
        for (int c = 8; c >= 0; c--) begin
            int per;
            per = 256 * div_tab[c] * (f44_tab[c] ? 2 : 1);
            set_rate(4'(c), w);
            wait_stb();
            if (!f44_tab[c])
                chk(last_stb_cyc - w == 256 * div_tab[c] + 2, "R5", "first strobe delay",
                    last_stb_cyc - w, 256 * div_tab[c] + 2);
            prev = last_stb_cyc;
            wait_stb();
            chk(last_stb_cyc - prev == per, "R2", "strobe period", last_stb_cyc - prev, per);
        end

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule